// File: doc/BRIEF.md
# Narrow External Memory Access Sequencer

This block sits between an on-chip request port and an external asynchronous memory whose data bus is 8 or 16 bits wide. It accepts one read or write at a time, of 8, 16 or 32 bits. It breaks each request into as many narrow external accesses as the device width needs. Each external access is driven through a setup, a strobe and a hold phase. The length of every phase comes from a programmable timing set, and that set is picked per request by a memory space code.

For writes, the timing set also gives a drive delay. This is the cycle within each access at which the block starts putting write data on the external bus. Requests the device cannot serve are refused at once with an error response, and no external access is made. Read data from the narrow accesses is assembled into one bus word. It is returned together with a single-cycle ready pulse when the last access ends.

Top module: `smemSplitter`

## Requirements
- R1: With `devWide`=0 (8-bit device), size code 0 (8 bits) makes 1 external access, code 1 (16 bits) makes 2 and code 2 (32 bits) makes 4. After the last access `memCsN` returns high.
- R2: With `devWide`=1 (16-bit device), size code 1 makes 1 access and size code 2 makes 2. An 8-bit read makes 1 access, and its result is `memDin[7:0]` in `rspRdata[7:0]`.
- R3: Sub-access k (k = 0 first) drives `memAddr` = request address + k. On an 8-bit device, write byte k (`reqWdata[8k+7:8k]`) goes out on `memDout[7:0]` with `memDout[15:8]`=0. On a 16-bit device, halfword k goes out on `memDout`.
- R4: Each access holds `memCsN` low for (S+1)+(W+1)+(H+1) cycles, where S, W and H are the setup, strobe and hold fields. The strobe is low only during the W+1 middle cycles: `memOeN` for reads, `memWeN` for writes. Timing words place S in bits [7:0], W in [15:8], H in [23:16] and the drive delay D in [31:24].
- R5: On a write, `memDoutEn` is high in every cycle of an access whose index, counted from 0 at the first setup cycle, is at least D. It is never high on reads or outside an access.
- R6: Space code 0 selects `timCommon`, code 1 selects `timAttr` and code 2 selects `timIo`. The set is sampled when the request is accepted.
- R7: Read data is sampled at the end of the last strobe cycle. On an 8-bit device, access k fills `rspRdata[8k+7:8k]`. On a 16-bit device, access k of a 32-bit read fills `rspRdata[16k+15:16k]`. Bits not filled read as 0.
- R8: `rspReady` is high for exactly one cycle: the last hold cycle of the last access. `rspRdata` holds the assembled value in that cycle, and `rspError` is 0.
- R9: A request with size code 3, space code 3, or an 8-bit write to a 16-bit device is refused. In the cycle after acceptance, `rspReady` and `rspError` are both 1 and `memCsN` stays high. In the following cycle the block is idle.
- R10: During reset, `memCsN`, `memOeN` and `memWeN` are high, and `memDoutEn` and `rspReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present (taken when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 = 8, 1 = 16, 2 = 32 bits, 3 = reserved |
| reqSpace | input | 2 | 0 common, 1 attribute, 2 I/O, 3 reserved |
| reqAddr | input | ADDR_W | External start address |
| reqWdata | input | 32 | Write data, little-endian lanes |
| devWide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| timCommon | input | 32 | Timing word for common space |
| timAttr | input | 32 | Timing word for attribute space |
| timIo | input | 32 | Timing word for I/O space |
| rspReady | output | 1 | One-cycle completion pulse |
| rspError | output | 1 | Refusal flag, valid with rspReady |
| rspRdata | output | 32 | Assembled read data |
| memAddr | output | ADDR_W | External address |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Read strobe, active low |
| memWeN | output | 1 | Write strobe, active low |
| memDout | output | 16 | Write data to the device |
| memDoutEn | output | 1 | Write data bus drive enable |
| memDin | input | 16 | Read data from the device |

## Verification
The embedded properties assume that a new request is raised only while the block is idle, that is, never between acceptance and the ready pulse. They also assume that `memDin` settles before the end of a strobe phase. The bench raises `reqValid` for a single cycle, only when the block is idle, and changes the timing words and `devWide` only between transactions. It models the device as a combinational function of `memAddr`, so the read data is stable whenever it is sampled.

// File: rtl/smemPkg.sv
package smemPkg;
  localparam int PH_W  = 8;
  localparam int ACC_W = PH_W + 2;
  localparam int BUS_W = 32;
  localparam int MEM_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_FAULT
  } phaseE;

  // timing word: drive in [31:24], hold [23:16], strobe [15:8], setup [7:0]
  typedef struct packed {
    logic [PH_W-1:0] drive;
    logic [PH_W-1:0] hold;
    logic [PH_W-1:0] strobe;
    logic [PH_W-1:0] setup;
  } timingT;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
  } strobesT;
endpackage

// File: rtl/smemCtrl.sv
module smemCtrl
  import smemPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSize,
  input  logic [1:0] reqSpace,
  input  logic       devWide,
  input  timingT     timCommon,
  input  timingT     timAttr,
  input  timingT     timIo,
  output strobesT    strb,
  output logic       memCsN,
  output logic       memOeN,
  output logic       memWeN,
  output logic       memDoutEn,
  output logic       rspReady,
  output logic       rspError
);
  phaseE            state;
  timingT           tim;
  timingT           pick;
  logic [PH_W-1:0]  phaseCnt;
  logic [ACC_W-1:0] accCyc;
  logic [1:0]       subLeft;
  logic [1:0]       subTotal;
  logic             isWrite;
  logic             reqBad;
  logic             active;
  logic             phaseEnd;

  // R9 refusal, R6 timing set choice, R1/R2 access count
  always_comb begin
    reqBad = (reqSize == 2'd3) || (reqSpace == 2'd3) ||
             (devWide && reqWrite && reqSize == 2'd0);
    case (reqSpace)
      2'd0:    pick = timCommon;
      2'd1:    pick = timAttr;
      default: pick = timIo;
    endcase
    if (devWide) subTotal = (reqSize == 2'd2) ? 2'd1 : 2'd0;
    else         subTotal = (reqSize == 2'd2) ? 2'd3 :
                            (reqSize == 2'd1) ? 2'd1 : 2'd0;
  end

  assign active   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign phaseEnd = (phaseCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tim      <= '0;
      phaseCnt <= '0;
      accCyc   <= '0;
      subLeft  <= '0;
      isWrite  <= 1'b0;
    end else begin
      if (active && accCyc != '1) accCyc <= accCyc + ACC_W'(1);
      case (state)
        ST_IDLE: if (reqValid) begin
          if (reqBad) state <= ST_FAULT;
          else begin
            state    <= ST_SETUP;
            tim      <= pick;
            phaseCnt <= pick.setup;
            accCyc   <= '0;
            subLeft  <= subTotal;
            isWrite  <= reqWrite;
          end
        end
        ST_SETUP:
          if (phaseEnd) begin
            state    <= ST_STROBE;
            phaseCnt <= tim.strobe;
          end else phaseCnt <= phaseCnt - PH_W'(1);
        ST_STROBE:
          if (phaseEnd) begin
            state    <= ST_HOLD;
            phaseCnt <= tim.hold;
          end else phaseCnt <= phaseCnt - PH_W'(1);
        ST_HOLD:
          if (phaseEnd) begin
            if (subLeft == '0) state <= ST_IDLE;
            else begin
              state    <= ST_SETUP;
              phaseCnt <= tim.setup;
              accCyc   <= '0;
              subLeft  <= subLeft - 2'd1;
            end
          end else phaseCnt <= phaseCnt - PH_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && reqValid && !reqBad;
    strb.capture = (state == ST_STROBE) && phaseEnd && !isWrite;
    strb.advance = (state == ST_HOLD) && phaseEnd && (subLeft != '0);
  end

  assign memCsN    = !active;
  assign memOeN    = !((state == ST_STROBE) && !isWrite);
  assign memWeN    = !((state == ST_STROBE) && isWrite);
  assign memDoutEn = active && isWrite && (ACC_W'(tim.drive) <= accCyc);
  assign rspReady  = ((state == ST_HOLD) && phaseEnd && (subLeft == '0)) ||
                     (state == ST_FAULT);
  assign rspError  = (state == ST_FAULT);

  a_r4_strobe_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !memCsN);
  a_r4_setup_precedes_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCsN) |-> (memOeN && memWeN));
  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDoutEn);
  a_r8_ready_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspReady);
  a_r9_refusal_no_access: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> (memCsN && !memDoutEn));
endmodule

// File: rtl/smemDatapath.sv
module smemDatapath
  import smemPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobesT           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic [1:0]        reqSize,
  input  logic              devWide,
  input  logic [MEM_W-1:0]  memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [MEM_W-1:0]  memDout,
  output logic [BUS_W-1:0]  rspRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  wdataQ;
  logic [BUS_W-1:0]  rdataQ;
  logic              narrowQ;
  logic              wideQ;
  logic [1:0]        subIdx;
  logic [7:0]        byteSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdataQ  <= '0;
      narrowQ <= 1'b0;
      wideQ   <= 1'b0;
      subIdx  <= '0;
    end else if (strb.load) begin
      addrQ   <= reqAddr;
      wdataQ  <= reqWdata;
      rdataQ  <= '0;
      narrowQ <= (reqSize == 2'd0);
      wideQ   <= devWide;
      subIdx  <= '0;
    end else begin
      if (strb.advance) begin
        addrQ  <= addrQ + ADDR_W'(1);
        subIdx <= subIdx + 2'd1;
      end
      if (strb.capture) begin
        if (wideQ) begin
          if (narrowQ)        rdataQ[7:0]   <= memDin[7:0];
          else if (subIdx[0]) rdataQ[31:16] <= memDin;
          else                rdataQ[15:0]  <= memDin;
        end else begin
          case (subIdx)
            2'd0:    rdataQ[7:0]   <= memDin[7:0];
            2'd1:    rdataQ[15:8]  <= memDin[7:0];
            2'd2:    rdataQ[23:16] <= memDin[7:0];
            default: rdataQ[31:24] <= memDin[7:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    case (subIdx)
      2'd0:    byteSel = wdataQ[7:0];
      2'd1:    byteSel = wdataQ[15:8];
      2'd2:    byteSel = wdataQ[23:16];
      default: byteSel = wdataQ[31:24];
    endcase
    if (wideQ) memDout = subIdx[0] ? wdataQ[31:16] : wdataQ[15:0];
    else       memDout = {8'h00, byteSel};
  end

  assign memAddr  = addrQ;
  assign rspRdata = rdataQ;

  a_r3_address_steps_by_one: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (memAddr == $past(memAddr) + ADDR_W'(1)));
  a_r7_capture_not_on_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.capture);
endmodule

// File: rtl/smemSplitter.sv
module smemSplitter
  import smemPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqSpace,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic              devWide,
  input  logic [31:0]       timCommon,
  input  logic [31:0]       timAttr,
  input  logic [31:0]       timIo,
  output logic              rspReady,
  output logic              rspError,
  output logic [31:0]       rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [15:0]       memDout,
  output logic              memDoutEn,
  input  logic [15:0]       memDin
);
  strobesT strb;

  smemCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqSpace(reqSpace), .devWide(devWide),
    .timCommon(timingT'(timCommon)), .timAttr(timingT'(timAttr)),
    .timIo(timingT'(timIo)), .strb(strb), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .memDoutEn(memDoutEn), .rspReady(rspReady),
    .rspError(rspError)
  );

  smemDatapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqSize(reqSize), .devWide(devWide),
    .memDin(memDin), .memAddr(memAddr), .memDout(memDout),
    .rspRdata(rspRdata)
  );

  a_r3_write_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memDout));
  a_r3_address_stable_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ((!memOeN || !memWeN) && $past(!memOeN || !memWeN)) |-> $stable(memAddr));
endmodule

// File: tb/smemSplitter_tb.sv
module smemSplitter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, devWide = 1'b0;
  logic [1:0]  reqSize = '0, reqSpace = '0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] timCommon = '0, timAttr = '0, timIo = '0;
  logic        rspReady, rspError, memCsN, memOeN, memWeN, memDoutEn;
  logic [31:0] rspRdata;
  logic [15:0] memAddr, memDout, memDin;
  int runs = 0, fails = 0;
  int ts[3], tw[3], th[3], td[3];
  bit done = 0;

  always #5 clk = ~clk;

  // device model: read data is a fixed function of the address
  assign memDin = {memAddr[7:0] ^ 8'h5A, memAddr[7:0] + 8'h11};

  smemSplitter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqSpace(reqSpace), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .devWide(devWide), .timCommon(timCommon),
    .timAttr(timAttr), .timIo(timIo), .rspReady(rspReady),
    .rspError(rspError), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic setTimings();
    timCommon = {8'(td[0]), 8'(th[0]), 8'(tw[0]), 8'(ts[0])};
    timAttr   = {8'(td[1]), 8'(th[1]), 8'(tw[1]), 8'(ts[1])};
    timIo     = {8'(td[2]), 8'(th[2]), 8'(tw[2]), 8'(ts[2])};
  endtask

  task automatic runTxn(input bit wr, input int sz, input int sp, input bit wide,
                        input logic [15:0] base, input logic [31:0] wd);
    bit bad;
    int n, s, w, h, d, total;
    logic [31:0] expRd, sh;
    logic [15:0] din, expDout, a;
    bit last, expEn, expOe, expWe;
    reqValid = 1'b1; reqWrite = wr; reqSize = 2'(sz); reqSpace = 2'(sp);
    devWide = wide; reqAddr = base; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    bad = (sz == 3) || (sp == 3) || (wide && wr && sz == 0);
    if (bad) begin
      check(rspReady && rspError && memCsN, "R9 refusal response",
            {29'd0, rspReady, rspError, memCsN}, 32'h7);
      @(negedge clk);
      check(!rspReady && memCsN, "R9 idle after refusal",
            {30'd0, rspReady, memCsN}, 32'h1);
      return;
    end
    n = wide ? ((sz == 2) ? 2 : 1) : (1 << sz);
    s = ts[sp]; w = tw[sp]; h = th[sp]; d = td[sp];   // R6 set per space
    total = s + w + h + 3;
    expRd = '0;
    for (int k = 0; k < n; k++) begin
      a = base + 16'(k);
      for (int c = 0; c < total; c++) begin
        expOe = !(!wr && c > s && c <= s + w + 1);
        expWe = !(wr && c > s && c <= s + w + 1);
        expEn = wr && (c >= d);
        last  = (k == n - 1) && (c == total - 1);
        check(!memCsN && memOeN == expOe && memWeN == expWe, "R4 R6 phase strobes",
              {29'd0, memCsN, memOeN, memWeN}, {29'd0, 1'b0, expOe, expWe});
        check(memDoutEn == expEn, "R5 drive enable", {31'd0, memDoutEn}, {31'd0, expEn});
        check(memAddr == a, "R3 sub-access address", {16'd0, memAddr}, {16'd0, a});
        check(rspReady == last && !rspError, "R8 ready timing",
              {30'd0, rspReady, rspError}, {30'd0, last, 1'b0});
        if (wr && expEn) begin
          sh = wide ? (wd >> (16 * k)) : (wd >> (8 * k));
          expDout = wide ? sh[15:0] : {8'h00, sh[7:0]};
          check(memDout == expDout, "R3 write lane order", {16'd0, memDout}, {16'd0, expDout});
        end
        if (!wr && c == s + w + 1) begin
          din = {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
          if (wide && sz == 0) expRd[7:0] = din[7:0];                // R2
          else if (wide) expRd = expRd | ({16'd0, din} << (16 * k));
          else expRd = expRd | ({24'd0, din[7:0]} << (8 * k));
        end
        if (last && !wr)
          check(rspRdata == expRd, "R7 R2 assembled read", rspRdata, expRd);
        @(negedge clk);
      end
    end
    check(memCsN && !rspReady, "R1 R2 access count",
          {30'd0, memCsN, rspReady}, 32'h2);
  endtask

  task automatic sweep();
    for (int sp = 0; sp < 3; sp++)
      for (int wide = 0; wide < 2; wide++)
        for (int sz = 0; sz < 3; sz++)
          for (int wr = 0; wr < 2; wr++)
            runTxn(wr[0], sz, sp, wide[0], 16'h0100 + 16'(sp * 16 + sz * 4),
                   32'hC3B2A190 ^ (sp * 32'h01010101));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    ts = '{1, 0, 2}; tw = '{2, 0, 1}; th = '{0, 2, 1}; td = '{1, 0, 3};
    setTimings();
    repeat (3) @(negedge clk);
    check(memCsN && memOeN && memWeN && !memDoutEn && !rspReady, "R10 reset state",
          {27'd0, memCsN, memOeN, memWeN, memDoutEn, rspReady}, 32'h1C);
    rstN = 1'b1;
    @(negedge clk);
    check(memCsN && !rspReady, "R10 idle after reset", {30'd0, memCsN, rspReady}, 32'h2);
    sweep();
    runTxn(1'b0, 1, 3, 1'b0, 16'h0200, 32'h0);         // R9 reserved space
    runTxn(1'b1, 3, 0, 1'b1, 16'h0200, 32'h0);         // R9 reserved size
    runTxn(1'b1, 0, 1, 1'b1, 16'h0200, 32'h12345678);  // R9 byte write, wide device
    // second timing configuration: long setup, drive delay past the access end
    ts = '{5, 0, 3}; tw = '{3, 4, 0}; th = '{1, 0, 2}; td = '{2, 0, 250};
    setTimings();
    sweep();
    runTxn(1'b0, 2, 2, 1'b1, 16'hFFFF, 32'h0);         // R3 address wrap
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule